// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Data Cache

This block is a small data cache that sits between a processor port and a lower-level memory. It holds 1 KB as 16 sets of two 32-byte lines. Each access splits its 32-bit address into a byte offset, a set index and a tag. The two lines of the selected set are tag-compared at the same time. The matching line supplies the read word. A read miss fills one whole line from memory. The line it replaces is the one used less recently in that set.

Stores use a write-through policy. Every store goes into a four-entry first-in first-out write buffer. If the line is present, the store also updates it. A store that misses does not fill a line. The memory side empties the buffer one entry at a time, in order. If a store finds the buffer full, the processor waits. A read miss does not ask for its line until the buffer is empty, so a refill can never return stale data.

Control is a four-state machine:
- `S_IDLE` waits for a request (transition *accept* goes to `S_LOOKUP`).
- `S_LOOKUP` compares the tags. Its transitions are:
  - *hit-done*, read hit, to `S_IDLE`.
  - *store-done*, store with buffer space, to `S_IDLE`.
  - *store-stall*, buffer full, stays in `S_LOOKUP`.
  - *miss-drain*, read miss with the buffer not empty, to `S_DRAIN`.
  - *miss-fill*, read miss with the buffer empty, to `S_REFILL`.
- `S_DRAIN` waits for an empty buffer (transition *drained* goes to `S_REFILL`).
- `S_REFILL` takes eight words. After the last word (transition *fill-done*) it returns to `S_LOOKUP`, which then finds a hit.

Top module: `wt_cache2w`

## Requirements
- R1: Address bits [4:0] are the byte offset, and bits [4:2] select one of the 8 words in a line. Bits [8:5] select one of the 16 sets. Bits [31:9] are the tag.
- R2: A read hit raises `cpu_ready` at the first falling edge after the request is taken, returns the stored word, and makes no memory request.
- R3: A hit is the OR of the two per-way tag matches, and at most one way matches. Two lines with different tags live in the same set together.
- R4: On a read miss, `mem_rd_addr` gives the line address (offset bits zero). The block takes eight `mem_rd_valid` beats, carrying words 0 to 7 in order, into the victim way. It then returns the requested word.
- R5: Each set has one replacement bit that names the victim way. On a hit, it is set to the way that was not hit. On a refill, it is set to the way that was not filled. After reset it names way 0.
- R6: A store hit updates the cached word. A store miss does not fill a line, so a later read of that line misses.
- R7: Every accepted store enters a 4-entry first-in first-out buffer. Memory writes leave the buffer in store order. `mem_wr_addr` and `mem_wr_data` stay fixed while `mem_wr_valid` is high and `mem_wr_ready` is low. Memory changes only through this path.
- R8: A store that finds four entries in the buffer holds `cpu_ready` low until an entry drains.
- R9: A read miss does not raise `mem_rd_req` while `mem_wr_valid` is high.
- R10: After reset, all lines are invalid, the buffer is empty, and `cpu_ready`, `mem_rd_req` and `mem_wr_valid` are low.
- R11: `cpu_ready` is high for exactly one cycle for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Request, sampled while idle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| mem_rd_req | output | 1 | Line refill request |
| mem_rd_addr | output | 32 | Line-aligned refill address |
| mem_rd_valid | input | 1 | Refill word beat |
| mem_rd_data | input | 32 | Refill word |
| mem_wr_valid | output | 1 | Buffered write available |
| mem_wr_addr | output | 32 | Buffered write address |
| mem_wr_data | output | 32 | Buffered write data |
| mem_wr_ready | input | 1 | Memory accepts the buffered write |

## Verification
The assertions check these properties on every cycle:
- At most one way ever matches.
- The replacement bit moves away from the way that was hit.
- A refill request never overlaps a pending buffered write.
- Buffered write data stays put while the memory holds it off.
- The completion pulse lasts one cycle.

Only the bench scenarios can show the behaviour that depends on a history of accesses:
- Data correctness across every set, tag pair and word.
- Which line the least-recently-used choice evicts.
- That a store miss does not allocate a line.
- The order in which buffered stores reach memory.
- How long the stall lasts when the buffer is full.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOOKUP = 2'd1,
        S_DRAIN  = 2'd2,
        S_REFILL = 2'd3
    } wtc_state_t;
endpackage

// File: rtl/wtc_way.sv
// One way: valid bits, tags and line words, with a combinational tag match.
module wtc_way #(
    parameter int SETS   = 16,
    parameter int WPL    = 8,
    parameter int TAG_W  = 23,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WSEL_W = $clog2(WPL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [WSEL_W-1:0] lk_word,
    output logic              hit,
    output logic [DATA_W-1:0] rdata,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fill_en
);
    logic [DATA_W-1:0] line_q [SETS*WPL];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [SETS-1:0]   valid_q;

    always_ff @(posedge clk) begin
        if (wr_en) line_q[{lk_idx, wr_word}] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[lk_idx] <= lk_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       valid_q <= '0;
        else if (fill_en) valid_q[lk_idx] <= 1'b1;
    end

    assign hit   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign rdata = line_q[{lk_idx, lk_word}];
endmodule

// File: rtl/wtc_wbuf.sv
// First-in first-out write buffer toward the lower-level memory.
module wtc_wbuf #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    output logic          full,
    output logic          empty,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data,
    input  logic          out_ready
);
    logic [AW-1:0]  addr_q [DEPTH];
    logic [DW-1:0]  data_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [PTR_W:0]   cnt_q;
    logic do_push, do_pop;

    assign full      = (cnt_q == (PTR_W+1)'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign out_valid = !empty;
    assign out_addr  = addr_q[rd_ptr_q];
    assign out_data  = data_q[rd_ptr_q];
    assign do_push   = push && !full;
    assign do_pop    = out_valid && out_ready;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            addr_q[wr_ptr_q] <= push_addr;
            data_q[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wt_cache2w.sv
module wt_cache2w
    import wtc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 16,
    parameter int WB_DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ready
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int BSEL_W = $clog2(DATA_W/8);
    localparam int WPL    = LINE_BYTES / (DATA_W/8);
    localparam int WSEL_W = $clog2(WPL);
    localparam int NWAYS  = 2;

    wtc_state_t st_q, st_d;

    logic [ADDR_W-1:0] req_addr_q;
    logic              req_we_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic [WSEL_W-1:0] beat_q;
    logic [SETS-1:0]   lru_q;

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [WSEL_W-1:0] lk_word;
    logic [NWAYS-1:0]  way_hit, wr_en_w, fill_en_w;
    logic [DATA_W-1:0] way_rdata [NWAYS];
    logic              hit_any, hit_way, victim;
    logic [WSEL_W-1:0] wr_word;
    logic [DATA_W-1:0] wr_data;
    logic              lru_we, lru_val;
    logic              wb_push, wb_full, wb_empty;

    assign lk_idx  = req_addr_q[OFF_W +: IDX_W];
    assign lk_tag  = req_addr_q[ADDR_W-1 -: TAG_W];
    assign lk_word = req_addr_q[BSEL_W +: WSEL_W];
    assign hit_any = |way_hit;
    assign hit_way = way_hit[1];
    assign victim  = lru_q[lk_idx];
    assign mem_rd_addr = {lk_tag, lk_idx, {OFF_W{1'b0}}};

    for (genvar g = 0; g < NWAYS; g++) begin : g_way
        wtc_way #(.SETS(SETS), .WPL(WPL), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
            .clk(clk), .rst_n(rst_n),
            .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_word(lk_word),
            .hit(way_hit[g]), .rdata(way_rdata[g]),
            .wr_en(wr_en_w[g]), .wr_word(wr_word), .wr_data(wr_data),
            .fill_en(fill_en_w[g])
        );
    end

    wtc_wbuf #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .push(wb_push), .push_addr(req_addr_q), .push_data(req_wdata_q),
        .full(wb_full), .empty(wb_empty),
        .out_valid(mem_wr_valid), .out_addr(mem_wr_addr), .out_data(mem_wr_data),
        .out_ready(mem_wr_ready)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Request capture, refill beat counter, replacement bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr_q  <= '0;
            req_we_q    <= 1'b0;
            req_wdata_q <= '0;
            beat_q      <= '0;
            lru_q       <= '0;
        end else begin
            if (st_q == S_IDLE && cpu_req) begin
                req_addr_q  <= cpu_addr;
                req_we_q    <= cpu_we;
                req_wdata_q <= cpu_wdata;
            end
            if (st_q == S_REFILL && mem_rd_valid) beat_q <= beat_q + 1'b1;
            if (lru_we) lru_q[lk_idx] <= lru_val;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d       = st_q;
        cpu_ready  = 1'b0;
        cpu_rdata  = '0;
        mem_rd_req = 1'b0;
        wb_push    = 1'b0;
        wr_en_w    = '0;
        fill_en_w  = '0;
        wr_word    = lk_word;
        wr_data    = req_wdata_q;
        lru_we     = 1'b0;
        lru_val    = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (cpu_req) st_d = S_LOOKUP;
            end
            S_LOOKUP: begin
                if (req_we_q) begin
                    if (!wb_full) begin
                        cpu_ready = 1'b1;
                        wb_push   = 1'b1;
                        st_d      = S_IDLE;
                        if (hit_any) begin
                            wr_en_w[hit_way] = 1'b1;
                            lru_we  = 1'b1;
                            lru_val = ~hit_way;
                        end
                    end
                end else if (hit_any) begin
                    cpu_ready = 1'b1;
                    cpu_rdata = way_rdata[hit_way];
                    lru_we    = 1'b1;
                    lru_val   = ~hit_way;
                    st_d      = S_IDLE;
                end else begin
                    st_d = wb_empty ? S_REFILL : S_DRAIN;
                end
            end
            S_DRAIN: begin
                if (wb_empty) st_d = S_REFILL;
            end
            S_REFILL: begin
                mem_rd_req = 1'b1;
                wr_word    = beat_q;
                wr_data    = mem_rd_data;
                if (mem_rd_valid) begin
                    wr_en_w[victim] = 1'b1;
                    if (beat_q == WSEL_W'(WPL-1)) begin
                        fill_en_w[victim] = 1'b1;
                        lru_we  = 1'b1;
                        lru_val = ~victim;
                        st_d    = S_LOOKUP;
                    end
                end
            end
            default: st_d = S_IDLE;
        endcase
    end
endmodule

// File: rtl/wtc_chk.sv
module wtc_chk #(
    parameter int SETS   = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              mem_rd_req,
    input logic              mem_wr_valid,
    input logic              mem_wr_ready,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [DATA_W-1:0] mem_wr_data,
    input logic [1:0]        way_hit,
    input logic [SETS-1:0]   lru_q,
    input logic [IDX_W-1:0]  lk_idx
);
    // R3
    one_way_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    // R9
    no_refill_with_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !mem_wr_valid);

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R11
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R5
    lru_away_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && (|way_hit)) |=> (lru_q[$past(lk_idx)] != $past(way_hit[1])));
endmodule

bind wt_cache2w wtc_chk #(.SETS(SETS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .mem_rd_req(mem_rd_req),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .way_hit(way_hit), .lru_q(lru_q), .lk_idx(lk_idx)
);

// File: tb/tb_wt_cache2w.sv
`timescale 1ns/1ps
module tb_wt_cache2w;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic cpu_ready;
    logic [31:0] cpu_rdata;
    logic mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic mem_wr_valid;
    logic [31:0] mem_wr_addr, mem_wr_data;
    logic mem_wr_ready = 1'b0;

    always #2 clk = ~clk;

    wt_cache2w dut (.*);

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [31:0] mem  [4096];
    logic [31:0] refm [4096];
    logic [31:0] ew_addr [256];
    logic [31:0] ew_data [256];
    int ew_head = 0, ew_tail = 0;
    int refills = 0, drains = 0;
    bit drain_en = 1'b1;

    function automatic logic [31:0] init_word(input int i);
        return (i * 32'h9E37_79B9) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] mk_addr(input int tag, input int set, input int word);
        return (tag << 9) | (set << 5) | (word << 2);
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Memory responder
    initial begin
        bit rd_busy = 1'b0;
        int rd_beat = 0;
        int rd_base = 0;
        forever begin
            @(negedge clk);
            mem_wr_ready = drain_en;
            if (mem_wr_valid && mem_wr_ready) begin
                check(mem_wr_addr == ew_addr[ew_head & 255], "R7", "drain order addr",
                      mem_wr_addr, ew_addr[ew_head & 255]);
                check(mem_wr_data == ew_data[ew_head & 255], "R7", "drain order data",
                      mem_wr_data, ew_data[ew_head & 255]);
                mem[mem_wr_addr[13:2]] = mem_wr_data;
                ew_head++;
                drains++;
            end
            if (rd_busy && rd_beat == 8) begin
                mem_rd_valid = 1'b0;
                rd_busy = 1'b0;
            end else if (rd_busy) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = mem[rd_base + rd_beat];
                rd_beat++;
            end else if (mem_rd_req) begin
                check(!mem_wr_valid, "R9", "refill with pending write", 32'(mem_wr_valid), 0);
                check(mem_rd_addr[4:0] == 0, "R4", "refill addr aligned", mem_rd_addr, mem_rd_addr & ~32'h1f);
                rd_busy = 1'b1;
                rd_beat = 0;
                rd_base = int'(mem_rd_addr[13:2]);
                refills++;
            end
        end
    end

    task automatic do_access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                             input int hold, output logic [31:0] rd, output int lat);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            cpu_req = 1'b0;
            lat++;
            if (hold > 0 && lat == hold) drain_en = 1'b1;
        end while (!cpu_ready && lat < 3000);
        rd = cpu_rdata;
        if (we && cpu_ready) begin
            refm[addr[13:2]] = wd;
            ew_addr[ew_tail & 255] = addr;
            ew_data[ew_tail & 255] = wd;
            ew_tail++;
        end
    endtask

    task automatic wait_drained();
        int n = 0;
        while (ew_head != ew_tail && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(ew_head == ew_tail, "R7", "buffer drained", 32'(ew_head), 32'(ew_tail));
    endtask

    task automatic rd_check(input logic [31:0] addr, input int exp_ref, input string rq,
                            input string what);
        logic [31:0] d;
        int lat, r0;
        r0 = refills;
        do_access(1'b0, addr, '0, 0, d, lat);
        check(d == refm[addr[13:2]], rq, {what, " data"}, d, refm[addr[13:2]]);
        check(refills - r0 == exp_ref, rq, {what, " refills"}, 32'(refills - r0), 32'(exp_ref));
    endtask

    initial begin
        #600000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'(0), 32'(1));
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int lat, r0, d0;
        for (int i = 0; i < 4096; i++) begin
            mem[i]  = init_word(i);
            refm[i] = init_word(i);
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        check(cpu_ready == 0, "R10", "ready after reset", 32'(cpu_ready), 0);
        check(mem_rd_req == 0, "R10", "rd_req after reset", 32'(mem_rd_req), 0);
        check(mem_wr_valid == 0, "R10", "wr_valid after reset", 32'(mem_wr_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R4 R10: sweep all sets, two tags, all words
        for (int s = 0; s < 16; s++) begin
            for (int t = 0; t < 2; t++) begin
                for (int w = 0; w < 8; w++) begin
                    r0 = refills;
                    do_access(1'b0, mk_addr(t, s, w), '0, 0, d, lat);
                    check(d == refm[mk_addr(t, s, w) >> 2], "R4", "sweep data", d,
                          refm[mk_addr(t, s, w) >> 2]);
                    check(refills - r0 == (w == 0 ? 1 : 0), "R1", "sweep refill count",
                          32'(refills - r0), 32'(w == 0 ? 1 : 0));
                    if (w > 0) check(lat == 1, "R2", "hit latency", 32'(lat), 1);
                end
            end
        end
        // R3: both tags coexist in every set
        for (int s = 0; s < 16; s++)
            for (int t = 0; t < 2; t++)
                rd_check(mk_addr(t, s, 3), 0, "R3", "coexist hit");

        // R5: replacement order in set 5 (last touched tag 1 -> victim holds tag 0)
        rd_check(mk_addr(2, 5, 1), 1, "R5", "tag2 evicts tag0");
        rd_check(mk_addr(1, 5, 1), 0, "R5", "tag1 kept");
        rd_check(mk_addr(0, 5, 1), 1, "R5", "tag0 evicts tag2");
        rd_check(mk_addr(1, 5, 2), 0, "R5", "tag1 still kept");
        rd_check(mk_addr(2, 5, 0), 1, "R5", "tag2 misses again");

        // R6: store hit updates line
        do_access(1'b1, mk_addr(0, 2, 4), 32'hCAFE_0001, 0, d, lat);
        check(lat == 1, "R7", "store latency with space", 32'(lat), 1);
        rd_check(mk_addr(0, 2, 4), 0, "R6", "store hit readback");
        wait_drained();
        check(mem[mk_addr(0, 2, 4) >> 2] == 32'hCAFE_0001, "R7", "memory written",
              mem[mk_addr(0, 2, 4) >> 2], 32'hCAFE_0001);

        // R6: store miss does not allocate
        do_access(1'b1, mk_addr(6, 7, 5), 32'hBEEF_0002, 0, d, lat);
        wait_drained();
        rd_check(mk_addr(6, 7, 5), 1, "R6", "store miss no allocate");

        // R8: full buffer stalls the fifth store
        drain_en = 1'b0;
        repeat (2) @(negedge clk);
        d0 = drains;
        for (int k = 0; k < 4; k++) begin
            do_access(1'b1, mk_addr(9, 9, (k == 3) ? 0 : k), 32'h1000_0000 + k, 0, d, lat);
            check(lat == 1, "R7", "store accepted into buffer", 32'(lat), 1);
        end
        check(drains == d0, "R7", "no memory write while held", 32'(drains), 32'(d0));
        check(mem[mk_addr(9, 9, 1) >> 2] == init_word(mk_addr(9, 9, 1) >> 2), "R7",
              "memory untouched before drain", mem[mk_addr(9, 9, 1) >> 2],
              init_word(mk_addr(9, 9, 1) >> 2));
        do_access(1'b1, mk_addr(9, 9, 0), 32'h2000_0005, 12, d, lat);
        check(lat > 12, "R8", "stall while full", 32'(lat), 13);
        wait_drained();
        check(mem[mk_addr(9, 9, 0) >> 2] == 32'h2000_0005, "R7", "last store wins",
              mem[mk_addr(9, 9, 0) >> 2], 32'h2000_0005);

        // R9: read miss waits for the buffer to empty
        drain_en = 1'b0;
        repeat (2) @(negedge clk);
        do_access(1'b1, mk_addr(4, 11, 2), 32'h3000_0007, 0, d, lat);
        r0 = refills;
        do_access(1'b0, mk_addr(4, 12, 6), '0, 10, d, lat);
        check(lat > 10, "R9", "refill delayed by pending write", 32'(lat), 11);
        check(d == refm[mk_addr(4, 12, 6) >> 2], "R9", "data after delayed refill", d,
              refm[mk_addr(4, 12, 6) >> 2]);
        check(refills - r0 == 1, "R4", "single refill", 32'(refills - r0), 1);
        wait_drained();
        rd_check(mk_addr(4, 11, 2), 1, "R6", "stored word fetched after drain");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule